// File: doc/BRIEF.md
# Ethernet Status LED Driver

This block produces the logic levels for four active-low indicator lamps that belong to a 10/100 Ethernet MAC. The four lamps show power or transmit activity, link or activity, duplex or collision, and line speed. Its inputs are the link state, the speed, the duplex state and three event strobes. The strobes report a frame being sent, a frame being received and a collision. A single select input picks one of two ways of placing the events onto the lamps. Both ways show steady states and blink-on-event indications on the same lamps.

A free-running prescaler sets a blink phase. Each event strobe re-arms a private stretch timer that lasts one full blink period. Because of this, an event that lasts a single clock still shows as a visible toggle. All four pins come from flip-flops. The block has a synchronous active-high reset and no other housekeeping.

Top module: `eth_led_driver`

## Requirements
- R1: While `rst` is high at a clock edge, all four pins read 1 after that edge. The prescaler, the blink phase and the stretch timers are cleared. After release the blink phase is 0 and no event is active.
- R2: In both mappings, `led_spd_n` is 0 when `speed_100` is 1 and 1 when `speed_100` is 0.
- R3: With `map_sel`=0, `led_pwr_n` is 0 while no transmit stretch is active. While a transmit stretch is active, it equals the blink phase.
- R4: With `map_sel`=0 and `link_ok`=1, `led_link_n` is 0 while no receive stretch is active. While a receive stretch is active, it equals the blink phase.
- R5: With `map_sel`=0, `led_dplx_n` equals the blink phase while a collision stretch is active. Otherwise it is 0 in full duplex (`full_dup`=1) and 1 in half duplex.
- R6: With `map_sel`=1, `led_pwr_n` is 0 whatever the transmit strobe does.
- R7: With `map_sel`=1 and `link_ok`=1, `led_link_n` equals the blink phase while the transmit or the receive stretch is active. Otherwise it is 0.
- R8: With `map_sel`=1, `led_dplx_n` is the inverse of `full_dup`. Collisions have no effect on it.
- R9: When `link_ok` is 0, `led_link_n` is 1 in both mappings, even while activity is being stretched.
- R10: A strobe high at a clock edge loads its timer to 2·`HALF_PERIOD`. The event then counts as active for that many cycles, and a new strobe restarts the full count.
- R11: The blink phase starts at 0 after reset. It inverts every `HALF_PERIOD` clock cycles.
- R12: Every pin is registered. A pin sampled after clock edge k reflects the inputs present at edge k and the phase and timer state from before edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sel | input | 1 | 0 selects the per-event mapping, 1 the combined mapping |
| link_ok | input | 1 | Link is valid |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| full_dup | input | 1 | 1 for full duplex |
| tx_evt | input | 1 | Transmit in progress strobe |
| rx_evt | input | 1 | Receive in progress strobe |
| col_evt | input | 1 | Collision strobe |
| led_pwr_n | output | 1 | Power / transmit lamp, active low |
| led_link_n | output | 1 | Link / activity lamp, active low |
| led_dplx_n | output | 1 | Duplex / collision lamp, active low |
| led_spd_n | output | 1 | Speed lamp, active low |

## Verification
The hardest case to reach from the ports is a re-arm that lands inside a running stretch, close to a phase flip. If the timer is not fully reloaded, the lamp stops blinking a few cycles early. The bench shortens `HALF_PERIOD` to 4 so that phase flips come often. It places single-cycle strobes at chosen offsets inside a running stretch, and it runs a long random burst of strobes and static-input changes. A behavioural model checks every pin on every cycle. The scenarios also drop the link while a stretch is active and switch the mapping while events are pending.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

  typedef enum logic {
    MAP_PER_EVENT = 1'b0,
    MAP_COMBINED  = 1'b1
  } led_map_e;

  localparam int EVT_TX  = 0;
  localparam int EVT_RX  = 1;
  localparam int EVT_COL = 2;
  localparam int N_EVT   = 3;

  typedef struct packed {
    logic pwr;
    logic link;
    logic dplx;
    logic spd;
  } led_pins_t;

  localparam led_pins_t PINS_DARK = '{pwr: 1'b1, link: 1'b1, dplx: 1'b1, spd: 1'b1};

  function automatic logic pick_level(input logic active, input logic phase, input logic steady);
    return active ? phase : steady;
  endfunction

endpackage

// File: rtl/eth_led_blink.sv
module eth_led_blink #(
  parameter int HALF_PERIOD = 6_250_000
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o
);
  localparam int PW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF_PERIOD - 1);

  logic [PW-1:0] pre_q;
  logic          phase_q;
  logic          wrap;

  assign wrap = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      pre_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      pre_q   <= pre_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pre_q != LAST) |=> (phase_o == $past(phase_o))); // R11
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (pre_q == LAST) |=> (phase_o != $past(phase_o))); // R11
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (pre_q <= LAST)); // R11

endmodule

// File: rtl/eth_led_stretch.sv
module eth_led_stretch #(
  parameter int HOLD = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (strobe_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_STRETCH_DECAY: assert property (@(posedge clk) disable iff (rst)
    (!strobe_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10
  AST_STRETCH_REARM: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> active_o); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= LOAD)); // R10

endmodule

// File: rtl/eth_led_map.sv
module eth_led_map
  import eth_led_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             map_sel,
  input  logic             link_ok,
  input  logic             speed_100,
  input  logic             full_dup,
  input  logic [N_EVT-1:0] act_i,
  input  logic             phase_i,
  output led_pins_t        pins_o
);
  led_map_e  map;
  led_pins_t nxt;
  led_pins_t pins_q;
  logic      any_traffic;

  assign map         = led_map_e'(map_sel);
  assign any_traffic = act_i[EVT_TX] | act_i[EVT_RX];

  always_comb begin
    nxt.spd = ~speed_100;
    unique case (map)
      MAP_PER_EVENT: begin
        nxt.pwr  = pick_level(act_i[EVT_TX], phase_i, 1'b0);
        nxt.link = pick_level(act_i[EVT_RX], phase_i, 1'b0);
        nxt.dplx = pick_level(act_i[EVT_COL], phase_i, ~full_dup);
      end
      default: begin
        nxt.pwr  = 1'b0;
        nxt.link = pick_level(any_traffic, phase_i, 1'b0);
        nxt.dplx = ~full_dup;
      end
    endcase
    if (!link_ok) nxt.link = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_DARK;
    else     pins_q <= nxt;
  end

  assign pins_o = pins_q;

  AST_SPD_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pins_o.spd == !$past(speed_100))); // R2
  AST_PWR_COMBINED_LIT: assert property (@(posedge clk) disable iff (rst)
    map_sel |=> !pins_o.pwr); // R6
  AST_DPLX_COMBINED: assert property (@(posedge clk) disable iff (rst)
    map_sel |=> (pins_o.dplx == !$past(full_dup))); // R8
  AST_LINK_DOWN_OFF: assert property (@(posedge clk) disable iff (rst)
    !link_ok |=> pins_o.link); // R9
  AST_QUIET_LINK_LIT: assert property (@(posedge clk) disable iff (rst)
    (link_ok && act_i == '0) |=> !pins_o.link); // R4

endmodule

// File: rtl/eth_led_driver.sv
module eth_led_driver
  import eth_led_pkg::*;
#(
  parameter int HALF_PERIOD = 6_250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic map_sel,
  input  logic link_ok,
  input  logic speed_100,
  input  logic full_dup,
  input  logic tx_evt,
  input  logic rx_evt,
  input  logic col_evt,
  output logic led_pwr_n,
  output logic led_link_n,
  output logic led_dplx_n,
  output logic led_spd_n
);
  localparam int HOLD = 2 * HALF_PERIOD;

  logic             phase;
  logic [N_EVT-1:0] strobes;
  logic [N_EVT-1:0] active;
  led_pins_t        pins;

  assign strobes[EVT_TX]  = tx_evt;
  assign strobes[EVT_RX]  = rx_evt;
  assign strobes[EVT_COL] = col_evt;

  eth_led_blink #(.HALF_PERIOD(HALF_PERIOD)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase)
  );

  for (genvar e = 0; e < N_EVT; e++) begin : g_stretch
    eth_led_stretch #(.HOLD(HOLD)) u_stretch (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (strobes[e]),
      .active_o (active[e])
    );
  end

  eth_led_map u_map (
    .clk       (clk),
    .rst       (rst),
    .map_sel   (map_sel),
    .link_ok   (link_ok),
    .speed_100 (speed_100),
    .full_dup  (full_dup),
    .act_i     (active),
    .phase_i   (phase),
    .pins_o    (pins)
  );

  assign led_pwr_n  = pins.pwr;
  assign led_link_n = pins.link;
  assign led_dplx_n = pins.dplx;
  assign led_spd_n  = pins.spd;

endmodule

// File: tb/eth_led_driver_tb.sv
module eth_led_driver_tb;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic map_sel = 1'b0, link_ok = 1'b0, speed_100 = 1'b0, full_dup = 1'b0;
  logic tx_evt = 1'b0, rx_evt = 1'b0, col_evt = 1'b0;
  logic led_pwr_n, led_link_n, led_dplx_n, led_spd_n;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  eth_led_driver #(.HALF_PERIOD(HP)) u_dut (
    .clk(clk), .rst(rst), .map_sel(map_sel), .link_ok(link_ok),
    .speed_100(speed_100), .full_dup(full_dup), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .col_evt(col_evt), .led_pwr_n(led_pwr_n),
    .led_link_n(led_link_n), .led_dplx_n(led_dplx_n), .led_spd_n(led_spd_n)
  );

  // behavioural reference
  int tick = 0;
  bit ph = 0;
  int left_tx = 0, left_rx = 0, left_col = 0;
  bit e_pwr = 1, e_link = 1, e_dplx = 1, e_spd = 1;

  always @(posedge clk) begin
    bit np, nl, nd, ns, busy;
    if (rst) begin
      tick = 0; ph = 0; left_tx = 0; left_rx = 0; left_col = 0;
      e_pwr = 1; e_link = 1; e_dplx = 1; e_spd = 1;
    end else begin
      ns = (speed_100 == 1'b1) ? 1'b0 : 1'b1;
      if (map_sel == 1'b0) begin
        np = (left_tx > 0) ? ph : 1'b0;
        nl = (left_rx > 0) ? ph : 1'b0;
        if (left_col > 0) nd = ph;
        else nd = full_dup ? 1'b0 : 1'b1;
      end else begin
        busy = (left_tx > 0) || (left_rx > 0);
        np = 1'b0;
        nl = busy ? ph : 1'b0;
        nd = full_dup ? 1'b0 : 1'b1;
      end
      if (!link_ok) nl = 1'b1;
      e_pwr = np; e_link = nl; e_dplx = nd; e_spd = ns;
      left_tx  = tx_evt  ? 2*HP : (left_tx  > 0 ? left_tx  - 1 : 0);
      left_rx  = rx_evt  ? 2*HP : (left_rx  > 0 ? left_rx  - 1 : 0);
      left_col = col_evt ? 2*HP : (left_col > 0 ? left_col - 1 : 0);
      tick = tick + 1;
      if (tick == HP) begin tick = 0; ph = ~ph; end
    end
  end

  task automatic cmp(input string pin, input logic got, input bit exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pin %s at %0t: got %b expected %b", req, pin, $time, got, exp);
    end
  endtask

  function automatic string pin_req(input string pin);
    if (tag != "") return tag;
    return pin;
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      cmp("pwr",  led_pwr_n,  e_pwr,  (tag == "R12") ? (map_sel ? "R6" : "R3") : tag);
      cmp("link", led_link_n, e_link, (tag == "R12") ? (link_ok ? (map_sel ? "R7" : "R4") : "R9") : tag);
      cmp("dplx", led_dplx_n, e_dplx, (tag == "R12") ? (map_sel ? "R8" : "R5") : tag);
      cmp("spd",  led_spd_n,  e_spd,  (tag == "R12") ? "R2" : tag);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tx_evt = 1'b1;
      1: rx_evt = 1'b1;
      default: col_evt = 1'b1;
    endcase
    @(negedge clk);
    tx_evt = 1'b0; rx_evt = 1'b0; col_evt = 1'b0;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    wait_cyc(3);
    cmp("all", led_pwr_n & led_link_n & led_dplx_n & led_spd_n, 1'b1, "R1");
    rst = 1'b0; link_ok = 1'b1; full_dup = 1'b1; speed_100 = 1'b1;
    // R11 phase runs from 0, R12 latency
    tag = "R11"; wait_cyc(12);
    // R2 speed
    tag = "R2";
    speed_100 = 1'b0; wait_cyc(3); speed_100 = 1'b1; wait_cyc(3);
    // R3 tx in per-event map
    tag = "R3";
    pulse(0); wait_cyc(12);
    tx_evt = 1'b1; wait_cyc(20); tx_evt = 1'b0; wait_cyc(10);
    // R4 rx
    tag = "R4";
    pulse(1); wait_cyc(12);
    // R5 duplex and collision
    tag = "R5";
    full_dup = 1'b0; wait_cyc(3); pulse(2); wait_cyc(12);
    full_dup = 1'b1; pulse(2); wait_cyc(12);
    // R10 re-arm inside a stretch at several offsets
    tag = "R10";
    pulse(1); wait_cyc(3); pulse(1); wait_cyc(5); pulse(1); wait_cyc(14);
    pulse(0); wait_cyc(7); pulse(0); wait_cyc(12);
    // R6/R7/R8 combined map
    map_sel = 1'b1;
    tag = "R6"; pulse(0); wait_cyc(12);
    tag = "R7"; pulse(1); wait_cyc(4); pulse(0); wait_cyc(14);
    tag = "R8"; full_dup = 1'b0; pulse(2); wait_cyc(6); full_dup = 1'b1; pulse(2); wait_cyc(6);
    // R9 link down while stretched, both maps
    tag = "R9";
    pulse(1); link_ok = 1'b0; wait_cyc(10); link_ok = 1'b1; pulse(1); wait_cyc(3);
    map_sel = 1'b0; link_ok = 1'b0; pulse(1); wait_cyc(6); link_ok = 1'b1; wait_cyc(8);
    // R12 mixed random traffic
    tag = "R12";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tx_evt  = ($urandom_range(0, 9) == 0);
      rx_evt  = ($urandom_range(0, 9) == 0);
      col_evt = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) map_sel   = ~map_sel;
      if ($urandom_range(0, 59) == 0) link_ok   = ~link_ok;
      if ($urandom_range(0, 39) == 0) full_dup  = ~full_dup;
      if ($urandom_range(0, 39) == 0) speed_100 = ~speed_100;
    end
    tx_evt = 1'b0; rx_evt = 1'b0; col_evt = 1'b0;
    // R1 reset mid-run clears timers
    tag = "R1";
    pulse(0); rst = 1'b1; wait_cyc(2);
    cmp("all", led_pwr_n & led_link_n & led_dplx_n & led_spd_n, 1'b1, "R1");
    rst = 1'b0; map_sel = 1'b0; wait_cyc(3);
    cmp("pwr", led_pwr_n, 1'b0, "R1");
    wait_cyc(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule